// File: doc/BRIEF.md
# Hub Downstream Port Disable and Logical Renumbering

This block decides which logical port numbers a hub presents to its host for a fixed set of physical downstream ports. Two disable masks are held in configuration, one for self-powered operation and one for bus-powered operation. A power-mode input picks the mask that applies. Every port left enabled receives a logical number. By default the enabled ports are packed into a gap-free sequence that starts at 1 and follows ascending physical order. When explicit remapping is turned on, per-port logical-number fields are used instead, provided they form a legal numbering.

The block outputs the number of enabled ports and a physical-to-logical table. It also outputs the reverse logical-to-physical table and a non-removable bitmap re-indexed by logical port. All of these outputs are registered. They change only on the clock edge where the configuration-load strobe is high, and hold their values between loads. If an explicit numbering is illegal, an error flag is raised and the automatic packing is used instead.

Top module: `hub_port_renum`

## Requirements
- R1: After reset, and before any load, the port count, both tables, the logical non-removable bitmap and the error flag are all zero.
- R2: With `bus_mode` = 1 the mask `dis_bus` applies, and with `bus_mode` = 0 the mask `dis_self` applies. Bit i = 1 disables physical port i+1, and bit i = 0 leaves it available. The mask that is not selected has no effect.
- R3: `port_count` equals the number of zero bits in the selected mask.
- R4: With remapping off, the enabled ports get logical numbers 1 to `port_count` in ascending physical order.
- R5: A disabled port's field in `log_of_phys` (bits [i*LW +: LW] for physical port i+1) is 0, and its physical number appears nowhere in `phys_of_log`.
- R6: With `remap_en` = 1, a legal numbering is applied as given. A numbering is legal when every enabled port's field in `remap_num` (same bit layout as `log_of_phys`) is in 1..`port_count` and no two enabled ports share a value.
- R7: With `remap_en` = 1 and an illegal numbering (a zero, a value above the count, or a duplicate), `cfg_error` is 1 and the automatic numbering of R4 is used. The fields of disabled ports are ignored in this legality check.
- R8: Field k-1 of `phys_of_log` holds the 1-based physical number of the port with logical number k. For k above `port_count` the field is 0.
- R9: Bit k-1 of `nonrem_log` equals the `nonrem` bit of the physical port with logical number k, and is 0 for k above `port_count`.
- R10: The outputs take new values at the first clock edge where `load` = 1 and keep them on every edge where `load` = 0.
- R11: A load with `remap_en` = 0 clears `cfg_error`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Configuration-load strobe |
| bus_mode | input | 1 | 1 = bus-powered, 0 = self-powered |
| dis_self | input | NPORTS | Disable mask used in self-powered mode |
| dis_bus | input | NPORTS | Disable mask used in bus-powered mode |
| nonrem | input | NPORTS | Non-removable mask, by physical port |
| remap_en | input | 1 | Use explicit logical numbers |
| remap_num | input | NPORTS*LW | Requested logical number per physical port |
| port_count | output | LW | Number of enabled ports |
| log_of_phys | output | NPORTS*LW | Logical number per physical port |
| phys_of_log | output | NPORTS*LW | Physical number per logical slot |
| nonrem_log | output | NPORTS | Non-removable bitmap, by logical port |
| cfg_error | output | 1 | Explicit numbering was rejected |

## Verification
Two functions can act in the same load cycle: the check on the explicit numbering, and the fallback to automatic packing, together with the mask choice that sets the legal range. The bench provokes this with loads that combine a disabled port carrying an out-of-range request and an enabled port whose request exceeds the reduced count. Each such load is judged on the error flag and on both tables after the edge. Further loads flip the power mode so that the same explicit request is legal under one mask and illegal under the other.

// File: rtl/hpr_pkg.sv
package hpr_pkg;
    typedef enum logic {
        PWR_SELF = 1'b0,
        PWR_BUS  = 1'b1
    } pwr_mode_e;
endpackage

// File: rtl/hpr_compact.sv
module hpr_compact #(
    parameter int NPORTS = 4,
    parameter int LW     = $clog2(NPORTS + 1)
) (
    input  logic [NPORTS-1:0]    live,
    output logic [NPORTS*LW-1:0] num_flat
);
    logic [LW-1:0] run;

    always_comb begin
        run      = '0;
        num_flat = '0;
        for (int i = 0; i < NPORTS; i++) begin
            if (live[i]) begin
                run = run + LW'(1);
                num_flat[i*LW +: LW] = run;
            end
        end
    end
endmodule

// File: rtl/hpr_remap_check.sv
module hpr_remap_check #(
    parameter int NPORTS = 4,
    parameter int LW     = $clog2(NPORTS + 1)
) (
    input  logic [NPORTS-1:0]    live,
    input  logic [NPORTS*LW-1:0] req_flat,
    input  logic [LW-1:0]        count,
    output logic                 legal
);
    logic [LW-1:0] vi;

    always_comb begin
        legal = 1'b1;
        vi    = '0;
        for (int i = 0; i < NPORTS; i++) begin
            if (live[i]) begin
                vi = req_flat[i*LW +: LW];
                if ((vi == '0) || (vi > count))
                    legal = 1'b0;
                for (int j = i + 1; j < NPORTS; j++) begin
                    if (live[j] && (req_flat[j*LW +: LW] == vi))
                        legal = 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/hpr_invert.sv
module hpr_invert #(
    parameter int NPORTS = 4,
    parameter int LW     = $clog2(NPORTS + 1)
) (
    input  logic [NPORTS*LW-1:0] num_flat,
    input  logic [NPORTS-1:0]    nonrem,
    output logic [NPORTS*LW-1:0] phys_flat,
    output logic [NPORTS-1:0]    nonrem_by_log
);
    for (genvar k = 0; k < NPORTS; k++) begin : g_slot
        always_comb begin
            phys_flat[k*LW +: LW] = '0;
            nonrem_by_log[k]      = 1'b0;
            for (int i = 0; i < NPORTS; i++) begin
                if (num_flat[i*LW +: LW] == LW'(k + 1)) begin
                    phys_flat[k*LW +: LW] = LW'(i + 1);
                    nonrem_by_log[k]      = nonrem[i];
                end
            end
        end
    end
endmodule

// File: rtl/hub_port_renum.sv
module hub_port_renum
    import hpr_pkg::*;
#(
    parameter int NPORTS = 4,
    localparam int LW    = $clog2(NPORTS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic                 bus_mode,
    input  logic [NPORTS-1:0]    dis_self,
    input  logic [NPORTS-1:0]    dis_bus,
    input  logic [NPORTS-1:0]    nonrem,
    input  logic                 remap_en,
    input  logic [NPORTS*LW-1:0] remap_num,
    output logic [LW-1:0]        port_count,
    output logic [NPORTS*LW-1:0] log_of_phys,
    output logic [NPORTS*LW-1:0] phys_of_log,
    output logic [NPORTS-1:0]    nonrem_log,
    output logic                 cfg_error
);
    typedef struct packed {
        logic [LW-1:0]        count;
        logic [NPORTS*LW-1:0] p2l;
        logic [NPORTS*LW-1:0] l2p;
        logic [NPORTS-1:0]    nrl;
        logic                 err;
    } map_state_t;

    map_state_t st_d, st_q;

    pwr_mode_e            mode;
    logic [NPORTS-1:0]    live;
    logic [LW-1:0]        live_cnt;
    logic [NPORTS*LW-1:0] auto_map;
    logic [NPORTS*LW-1:0] req_masked;
    logic [NPORTS*LW-1:0] pick_map;
    logic [NPORTS*LW-1:0] inv_map;
    logic [NPORTS-1:0]    inv_nr;
    logic                 req_legal;
    logic                 use_req;

    // mask selection and enabled-port count
    always_comb begin
        mode     = pwr_mode_e'(bus_mode);
        live     = (mode == PWR_BUS) ? ~dis_bus : ~dis_self;
        live_cnt = '0;
        for (int i = 0; i < NPORTS; i++)
            live_cnt = live_cnt + LW'(live[i]);
    end

    hpr_compact #(.NPORTS(NPORTS), .LW(LW)) u_compact (
        .live     (live),
        .num_flat (auto_map)
    );

    hpr_remap_check #(.NPORTS(NPORTS), .LW(LW)) u_check (
        .live     (live),
        .req_flat (remap_num),
        .count    (live_cnt),
        .legal    (req_legal)
    );

    // explicit fields of disabled ports are forced to zero
    always_comb begin
        for (int i = 0; i < NPORTS; i++)
            req_masked[i*LW +: LW] = live[i] ? remap_num[i*LW +: LW] : '0;
        use_req  = remap_en && req_legal;
        pick_map = use_req ? req_masked : auto_map;
    end

    hpr_invert #(.NPORTS(NPORTS), .LW(LW)) u_invert (
        .num_flat      (pick_map),
        .nonrem        (nonrem),
        .phys_flat     (inv_map),
        .nonrem_by_log (inv_nr)
    );

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.count = live_cnt;
            st_d.p2l   = pick_map;
            st_d.l2p   = inv_map;
            st_d.nrl   = inv_nr;
            st_d.err   = remap_en && !req_legal;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign port_count  = st_q.count;
    assign log_of_phys = st_q.p2l;
    assign phys_of_log = st_q.l2p;
    assign nonrem_log  = st_q.nrl;
    assign cfg_error   = st_q.err;
endmodule

// File: rtl/hpr_checker.sv
module hpr_checker #(
    parameter int NPORTS = 4,
    localparam int LW    = $clog2(NPORTS + 1)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 load,
    input logic                 bus_mode,
    input logic [NPORTS-1:0]    dis_self,
    input logic [NPORTS-1:0]    dis_bus,
    input logic [NPORTS-1:0]    nonrem,
    input logic                 remap_en,
    input logic [LW-1:0]        port_count,
    input logic [NPORTS*LW-1:0] log_of_phys,
    input logic [NPORTS*LW-1:0] phys_of_log,
    input logic [NPORTS-1:0]    nonrem_log,
    input logic                 cfg_error
);
    logic [NPORTS-1:0] ck_live;
    int                ck_cnt;
    int                ck_nr;

    always_comb begin
        ck_live = bus_mode ? ~dis_bus : ~dis_self;
        ck_cnt  = $countones(ck_live);
        ck_nr   = $countones(ck_live & nonrem);
    end

    // R10
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(port_count) && $stable(log_of_phys) &&
                   $stable(phys_of_log) && $stable(nonrem_log) && $stable(cfg_error)));

    // R3
    count_tracks_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (int'(port_count) == $past(ck_cnt)));

    // R11
    no_error_auto_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !remap_en) |=> !cfg_error);

    // R9
    nonrem_population_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> ($countones(nonrem_log) == $past(ck_nr)));
endmodule

bind hub_port_renum hpr_checker #(.NPORTS(NPORTS)) u_hpr_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (load),
    .bus_mode    (bus_mode),
    .dis_self    (dis_self),
    .dis_bus     (dis_bus),
    .nonrem      (nonrem),
    .remap_en    (remap_en),
    .port_count  (port_count),
    .log_of_phys (log_of_phys),
    .phys_of_log (phys_of_log),
    .nonrem_log  (nonrem_log),
    .cfg_error   (cfg_error)
);

// File: tb/tb_hub_port_renum.sv
`timescale 1ns/1ps
module tb_hub_port_renum;
    localparam int N  = 4;
    localparam int LW = 3;

    typedef struct packed {
        logic                 bus;
        logic [N-1:0]         ds;
        logic [N-1:0]         db;
        logic [N-1:0]         nr;
        logic                 rm;
        logic [N-1:0][LW-1:0] rq;
        logic [LW-1:0]        cnt;
        logic [N-1:0][LW-1:0] p2l;
        logic [N-1:0][LW-1:0] l2p;
        logic [N-1:0]         nrl;
        logic                 err;
    } vec_t;

    // field order in concatenations: port/slot 4 first, port/slot 1 last
    localparam vec_t VECS [10] = '{
        // R4 all enabled, identity
        '{1'b0, 4'b0000, 4'b0000, 4'b0000, 1'b0, {3'd0,3'd0,3'd0,3'd0}, 3'd4,
          {3'd4,3'd3,3'd2,3'd1}, {3'd4,3'd3,3'd2,3'd1}, 4'b0000, 1'b0},
        // R2 R4 R5 R9 self mask, ports 1 and 3 off
        '{1'b0, 4'b0101, 4'b0000, 4'b1010, 1'b0, {3'd0,3'd0,3'd0,3'd0}, 3'd2,
          {3'd2,3'd0,3'd1,3'd0}, {3'd0,3'd0,3'd4,3'd2}, 4'b0011, 1'b0},
        // R2 bus mask selected, self mask ignored
        '{1'b1, 4'b0101, 4'b1000, 4'b1010, 1'b0, {3'd0,3'd0,3'd0,3'd0}, 3'd3,
          {3'd0,3'd3,3'd2,3'd1}, {3'd0,3'd3,3'd2,3'd1}, 4'b0010, 1'b0},
        // R3 R5 R9 all disabled
        '{1'b0, 4'b1111, 4'b0000, 4'b1111, 1'b0, {3'd0,3'd0,3'd0,3'd0}, 3'd0,
          {3'd0,3'd0,3'd0,3'd0}, {3'd0,3'd0,3'd0,3'd0}, 4'b0000, 1'b0},
        // R6 R8 legal explicit permutation
        '{1'b0, 4'b0000, 4'b0000, 4'b0001, 1'b1, {3'd2,3'd4,3'd1,3'd3}, 3'd4,
          {3'd2,3'd4,3'd1,3'd3}, {3'd3,3'd1,3'd4,3'd2}, 4'b0100, 1'b0},
        // R7 disabled port's request 7 ignored, R6 applied
        '{1'b0, 4'b0010, 4'b0000, 4'b1000, 1'b1, {3'd3,3'd1,3'd7,3'd2}, 3'd3,
          {3'd3,3'd1,3'd0,3'd2}, {3'd0,3'd4,3'd1,3'd3}, 4'b0100, 1'b0},
        // R7 duplicate request
        '{1'b0, 4'b0000, 4'b0000, 4'b0000, 1'b1, {3'd3,3'd2,3'd1,3'd1}, 3'd4,
          {3'd4,3'd3,3'd2,3'd1}, {3'd4,3'd3,3'd2,3'd1}, 4'b0000, 1'b1},
        // R7 request above count with one port off
        '{1'b0, 4'b1000, 4'b0000, 4'b0000, 1'b1, {3'd0,3'd4,3'd2,3'd1}, 3'd3,
          {3'd0,3'd3,3'd2,3'd1}, {3'd0,3'd3,3'd2,3'd1}, 4'b0000, 1'b1},
        // R7 zero request
        '{1'b0, 4'b0000, 4'b0000, 4'b1111, 1'b1, {3'd3,3'd2,3'd1,3'd0}, 3'd4,
          {3'd4,3'd3,3'd2,3'd1}, {3'd4,3'd3,3'd2,3'd1}, 4'b1111, 1'b1},
        // R2 R6 bus mode explicit, self mask all ones ignored
        '{1'b1, 4'b1111, 4'b0110, 4'b0000, 1'b1, {3'd1,3'd0,3'd0,3'd2}, 3'd2,
          {3'd1,3'd0,3'd0,3'd2}, {3'd0,3'd0,3'd1,3'd4}, 4'b0000, 1'b0}
    };

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 load = 1'b0;
    logic                 bus_mode = 1'b0;
    logic [N-1:0]         dis_self = '0;
    logic [N-1:0]         dis_bus = '0;
    logic [N-1:0]         nonrem = '0;
    logic                 remap_en = 1'b0;
    logic [N*LW-1:0]      remap_num = '0;
    logic [LW-1:0]        port_count;
    logic [N*LW-1:0]      log_of_phys;
    logic [N*LW-1:0]      phys_of_log;
    logic [N-1:0]         nonrem_log;
    logic                 cfg_error;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    hub_port_renum #(.NPORTS(N)) dut (
        .clk(clk), .rst_n(rst_n), .load(load), .bus_mode(bus_mode),
        .dis_self(dis_self), .dis_bus(dis_bus), .nonrem(nonrem),
        .remap_en(remap_en), .remap_num(remap_num), .port_count(port_count),
        .log_of_phys(log_of_phys), .phys_of_log(phys_of_log),
        .nonrem_log(nonrem_log), .cfg_error(cfg_error)
    );

    task automatic check(input string what, input logic [15:0] got, input logic [15:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", what, got, exp);
        end
    endtask

    task automatic drive(input vec_t v, input logic ld);
        @(negedge clk);
        bus_mode  = v.bus;
        dis_self  = v.ds;
        dis_bus   = v.db;
        nonrem    = v.nr;
        remap_en  = v.rm;
        remap_num = v.rq;
        load      = ld;
        @(negedge clk);
        load      = 1'b0;
    endtask

    task automatic check_vec(input int idx, input vec_t v);
        check($sformatf("R3 count v%0d", idx), 16'(port_count), 16'(v.cnt));
        check($sformatf("R4/R5/R6/R7 log_of_phys v%0d", idx), 16'(log_of_phys), 16'(v.p2l));
        check($sformatf("R8 phys_of_log v%0d", idx), 16'(phys_of_log), 16'(v.l2p));
        check($sformatf("R9 nonrem_log v%0d", idx), 16'(nonrem_log), 16'(v.nrl));
        check($sformatf("R7/R11 cfg_error v%0d", idx), 16'(cfg_error), 16'(v.err));
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: got hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 count", 16'(port_count), 16'd0);
        check("R1 tables", 16'(log_of_phys | phys_of_log), 16'd0);
        check("R1 flags", 16'({nonrem_log, cfg_error}), 16'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", 16'(port_count), 16'd0);

        for (int i = 0; i < 10; i++) begin
            drive(VECS[i], 1'b1);
            check_vec(i, VECS[i]);
        end

        // R10 inputs changed without load: outputs hold
        drive(VECS[0], 1'b0);
        @(negedge clk);
        check_vec(90, VECS[9]);
        // R10 one load edge applies the pending inputs
        @(negedge clk);
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        check_vec(91, VECS[0]);

        // R11 error cleared by automatic-mode load after an error
        drive(VECS[6], 1'b1);
        check("R7 error set", 16'(cfg_error), 16'd1);
        drive(VECS[1], 1'b1);
        check("R11 error cleared", 16'(cfg_error), 16'd0);

        // R1 reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset again count", 16'(port_count), 16'd0);
        check("R1 reset again tables", 16'(log_of_phys | phys_of_log), 16'd0);
        rst_n = 1'b1;

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule